// File: doc/BRIEF.md
# Character Fetch and Pixel Serialiser

This block drives the per-character fetch timing for a bitmap display that pairs every screen byte with an attribute byte. A horizontal counter advances once per pixel clock across a 448-clock line. Its low three bits form an eight-step character phase. Every fetch and latch event is decoded from that phase.

In the first half of each character the block presents an attribute fetch, and in the second half a screen fetch. Two active-low strobes each go low for one phase and rise on the following clock edge. The attribute strobe's rising edge captures the data bus into an attribute latch. The screen strobe's rising edge loads the data bus into an 8-bit shift register, and that edge coincides with the start of phase 0. The register then shifts one pixel out per clock, most significant bit first.

A linear fetch counter advances once per screen byte. A frame-end pulse clears it. The fetch address is a page-aligned display base of 0x4000 plus the counter value. Sync generation, border colour and address interleaving are handled elsewhere.

Top module: `vid_fetch_seq`

## Requirements
- R1: While `rst_ni` is low, `hcount_o` is 0, `fetch_addr_o` is 0x4000, `attr_o` is 0 and `pix_o` is 0.
- R2: `hcount_o` increases by one per clock from 0 to 447 and returns to 0 on the clock after 447.
- R3: The character phase is `hcount_o` modulo 8. `fetch_sel_o` is 0 (attribute fetch) in phases 0 to 3 and 1 (screen fetch) in phases 4 to 7.
- R4: On the clock edge that ends phase 3, `attr_o` takes the value of `mem_data_i`. On every other edge `attr_o` holds its value.
- R5: On the clock edge that ends phase 7, `mem_data_i` is loaded into the shift register. Bit 7 of that byte therefore appears on `pix_o` throughout phase 0.
- R6: On each edge that does not load, the shift register moves one place toward its MSB and shifts a 0 into its LSB. In phase k, `pix_o` shows bit 7-k of the byte loaded at the start of the character.
- R7: `fetch_addr_o` equals 0x4000 plus a 13-bit count. The count increases by one on the edge that ends phase 7 and is unchanged on every other edge.
- R8: When `frame_end_i` is high at an edge, the count becomes 0 on that edge. This takes priority over the increment in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_end_i | input | 1 | One-clock pulse at the end of a frame; clears the fetch count |
| mem_data_i | input | 8 | Byte returned by display memory for the current fetch address |
| fetch_addr_o | output | 16 | Display memory fetch address |
| fetch_sel_o | output | 1 | 0 = attribute fetch, 1 = screen byte fetch |
| pix_o | output | 1 | Serial pixel bit |
| attr_o | output | 8 | Latched attribute byte |
| hcount_o | output | 9 | Horizontal pixel count |

## Verification
The bench runs across more than one full line, so the 447-to-0 wrap is exercised. A counter that ran to 448, or wrapped one count early, would shift every phase decode on the next line. Byte patterns of all ones, all zeros and alternating bits, with the memory content changing between phases, expose three faults: a load taken one phase late, which shows as a stale leading pixel; a shift that runs in the wrong direction, which reverses the pixel order; and an attribute latch that captures in every phase, which lets the attribute follow the bus. Frame-end is pulsed in the middle of a character, on the loading edge itself, and held over several characters. A design that let the increment win over the clear would leave the address at base+1 instead of base.

// File: rtl/vfs_pkg.sv
package vfs_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PH_W   = $clog2(BYTE_W);
  typedef logic [PH_W-1:0] phase_t;
  // attribute fetch occupies the first half of the character, screen fetch the second
  localparam phase_t PH_ATTR_LAST = phase_t'(BYTE_W/2 - 1);
  localparam phase_t PH_SCR_LAST  = phase_t'(BYTE_W - 1);
endpackage

// File: rtl/vfs_hcounter.sv
module vfs_hcounter #(
  parameter int unsigned H_TOTAL = 448,
  localparam int unsigned HC_W  = $clog2(H_TOTAL)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [HC_W-1:0] hcount_o
);
  localparam logic [HC_W-1:0] HC_LAST = HC_W'(H_TOTAL - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  hcount_o <= '0;
    else if (hcount_o == HC_LAST) hcount_o <= '0;
    else                          hcount_o <= hcount_o + 1'b1;
  end
endmodule

// File: rtl/vfs_phase_decode.sv
module vfs_phase_decode
  import vfs_pkg::*;
(
  input  phase_t phase_i,
  output logic   fetch_sel_o,
  output logic   attr_stb_no,
  output logic   scr_stb_no
);
  // strobes are low for one phase; their rise is the following clock edge
  always_comb begin
    fetch_sel_o = phase_i[PH_W-1];
    attr_stb_no = (phase_i != PH_ATTR_LAST);
    scr_stb_no  = (phase_i != PH_SCR_LAST);
  end
endmodule

// File: rtl/vfs_addr_ctr.sv
module vfs_addr_ctr #(
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;   // frame end wins over a same-edge increment
    else if (inc_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/vfs_shifter.sv
module vfs_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic         pix_o
);
  logic [W-1:0] sreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sreg_q <= '0;
    else if (load_i) sreg_q <= data_i;
    else             sreg_q <= {sreg_q[W-2:0], 1'b0};
  end

  assign pix_o = sreg_q[W-1];
endmodule

// File: rtl/vid_fetch_seq.sv
module vid_fetch_seq
  import vfs_pkg::*;
#(
  parameter int unsigned H_TOTAL  = 448,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned CNT_W    = 13,
  parameter logic [15:0] SCR_BASE = 16'h4000,
  localparam int unsigned HC_W    = $clog2(H_TOTAL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_end_i,
  input  logic [BYTE_W-1:0] mem_data_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              fetch_sel_o,
  output logic              pix_o,
  output logic [BYTE_W-1:0] attr_o,
  output logic [HC_W-1:0]   hcount_o
);
  logic [CNT_W-1:0] cnt;
  logic             attr_stb_n, scr_stb_n;
  phase_t           phase;

  vfs_hcounter #(.H_TOTAL(H_TOTAL)) u_hcnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hcount_o (hcount_o)
  );

  assign phase = hcount_o[PH_W-1:0];

  vfs_phase_decode u_dec (
    .phase_i     (phase),
    .fetch_sel_o (fetch_sel_o),
    .attr_stb_no (attr_stb_n),
    .scr_stb_no  (scr_stb_n)
  );

  // a strobe that is low now rises on the next edge: that edge is the capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          attr_o <= '0;
    else if (!attr_stb_n) attr_o <= mem_data_i;
  end

  vfs_shifter #(.W(BYTE_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (!scr_stb_n),
    .data_i (mem_data_i),
    .pix_o  (pix_o)
  );

  vfs_addr_ctr #(.CNT_W(CNT_W)) u_actr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (!scr_stb_n),
    .clr_i  (frame_end_i),
    .cnt_o  (cnt)
  );

  assign fetch_addr_o = ADDR_W'(SCR_BASE) + ADDR_W'(cnt);
endmodule

// File: rtl/vfs_checker.sv
module vfs_checker
  import vfs_pkg::*;
#(
  parameter int unsigned H_TOTAL  = 448,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned CNT_W    = 13,
  parameter logic [15:0] SCR_BASE = 16'h4000,
  localparam int unsigned HC_W    = $clog2(H_TOTAL)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_end_i,
  input logic [BYTE_W-1:0] mem_data_i,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic              fetch_sel_o,
  input logic              pix_o,
  input logic [BYTE_W-1:0] attr_o,
  input logic [HC_W-1:0]   hcount_o
);
  localparam logic [HC_W-1:0] HC_LAST = HC_W'(H_TOTAL - 1);
  phase_t ph;
  logic [CNT_W-1:0] cnt_v;
  assign ph    = hcount_o[PH_W-1:0];
  assign cnt_v = CNT_W'(fetch_addr_o - ADDR_W'(SCR_BASE));

  assert_hc_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hcount_o == HC_LAST |=> hcount_o == '0);
  assert_hc_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hcount_o != HC_LAST |=> hcount_o == HC_W'($past(hcount_o) + 1'b1));
  assert_sel_half_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_sel_o == (ph > PH_ATTR_LAST));
  assert_attr_cap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph == PH_ATTR_LAST |=> attr_o == $past(mem_data_i));
  assert_attr_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph != PH_ATTR_LAST |=> $stable(attr_o));
  assert_load_msb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph == PH_SCR_LAST |=> pix_o == $past(mem_data_i[BYTE_W-1]));
  assert_shift_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph == PH_SCR_LAST |=> ##1 pix_o == $past(mem_data_i[BYTE_W-2], 2));
  assert_addr_inc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph == PH_SCR_LAST && !frame_end_i) |=> cnt_v == CNT_W'($past(cnt_v) + 1'b1));
  assert_addr_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph != PH_SCR_LAST && !frame_end_i) |=> $stable(fetch_addr_o));
  assert_frame_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i |=> fetch_addr_o == ADDR_W'(SCR_BASE));
endmodule

bind vid_fetch_seq vfs_checker #(
  .H_TOTAL(H_TOTAL), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SCR_BASE(SCR_BASE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .frame_end_i(frame_end_i), .mem_data_i(mem_data_i),
  .fetch_addr_o(fetch_addr_o), .fetch_sel_o(fetch_sel_o), .pix_o(pix_o),
  .attr_o(attr_o), .hcount_o(hcount_o)
);

// File: tb/vid_fetch_seq_bench.sv
module vid_fetch_seq_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_end_i = 1'b0;
  logic [7:0]  mem_data_i;
  logic [15:0] fetch_addr_o;
  logic        fetch_sel_o, pix_o;
  logic [7:0]  attr_o;
  logic [8:0]  hcount_o;
  logic [7:0]  seed = 8'h00;

  int n_chk = 0, n_fail = 0;
  int exp_hc, exp_cnt;
  logic [7:0] exp_attr, exp_sreg;

  always #2.5 clk_i = ~clk_i;

  // memory model: content depends on address and on which kind of fetch is presented
  assign mem_data_i = fetch_sel_o ? (fetch_addr_o[7:0] ^ seed)
                                  : ({fetch_addr_o[3:0], fetch_addr_o[7:4]} + (seed ^ 8'h5A));

  vid_fetch_seq u_vid_fetch_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_end_i(frame_end_i), .mem_data_i(mem_data_i),
    .fetch_addr_o(fetch_addr_o), .fetch_sel_o(fetch_sel_o), .pix_o(pix_o),
    .attr_o(attr_o), .hcount_o(hcount_o)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input bit was_load, input bit was_clr);
    check(hcount_o == 9'(exp_hc), "R2", "hcount", int'(hcount_o), exp_hc);
    check(fetch_sel_o == ((exp_hc % 8) >= 4), "R3", "fetch_sel", int'(fetch_sel_o), int'((exp_hc % 8) >= 4));
    check(attr_o == exp_attr, "R4", "attr", int'(attr_o), int'(exp_attr));
    if (was_load) check(pix_o == exp_sreg[7], "R5", "pix after load", int'(pix_o), int'(exp_sreg[7]));
    else          check(pix_o == exp_sreg[7], "R6", "pix shift", int'(pix_o), int'(exp_sreg[7]));
    if (was_clr) check(fetch_addr_o == 16'h4000 + 16'(exp_cnt), "R8", "addr clear", int'(fetch_addr_o), 16'h4000 + exp_cnt);
    else         check(fetch_addr_o == 16'h4000 + 16'(exp_cnt), "R7", "addr", int'(fetch_addr_o), 16'h4000 + exp_cnt);
  endtask

  // one pixel clock; bench model updated from the requirements
  task automatic step(input bit fe);
    int pre_ph;
    logic [7:0] pre_mem;
    frame_end_i = fe;
    #1;
    pre_ph  = exp_hc % 8;
    pre_mem = mem_data_i;
    @(posedge clk_i); #1;
    exp_hc = (exp_hc == 447) ? 0 : exp_hc + 1;
    if (pre_ph == 3) exp_attr = pre_mem;
    if (pre_ph == 7) exp_sreg = pre_mem; else exp_sreg = {exp_sreg[6:0], 1'b0};
    if (fe) exp_cnt = 0; else if (pre_ph == 7) exp_cnt = (exp_cnt + 1) % 8192;
    frame_end_i = 1'b0;
    check_all(pre_ph == 7, fe);
  endtask

  task automatic goto_phase(input int ph);
    while ((exp_hc % 8) != ph) step(1'b0);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check(hcount_o == 0, "R1", "hcount in reset", int'(hcount_o), 0);
    check(fetch_addr_o == 16'h4000, "R1", "addr in reset", int'(fetch_addr_o), 16'h4000);
    check(attr_o == 0, "R1", "attr in reset", int'(attr_o), 0);
    check(pix_o == 0, "R1", "pix in reset", int'(pix_o), 0);
    repeat (2) @(posedge clk_i);
    #1;
    check(hcount_o == 0, "R1", "hcount held in reset", int'(hcount_o), 0);
    exp_hc = 0; exp_cnt = 0; exp_attr = 8'h00; exp_sreg = 8'h00;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_line_wrap();
    seed = 8'h00;
    repeat (900) step(1'b0);   // two line wraps
  endtask

  task automatic t_patterns();
    logic [7:0] pats [4] = '{8'hFF, 8'h00, 8'hAA, 8'h3C};
    foreach (pats[i]) begin
      seed = pats[i];
      repeat (48) step(1'b0);
    end
  endtask

  task automatic t_frame_mid();
    goto_phase(2);
    step(1'b1);                 // R8 clear mid-character
    repeat (20) step(1'b0);
  endtask

  task automatic t_frame_on_load();
    goto_phase(7);
    step(1'b1);                 // R8 clear beats the same-edge increment
    repeat (12) step(1'b0);
  endtask

  task automatic t_frame_hold();
    goto_phase(5);
    repeat (20) step(1'b1);     // R8 held across characters
    repeat (10) step(1'b0);
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    exp_hc = 0; exp_cnt = 0; exp_attr = 8'h00; exp_sreg = 8'h00;
    t_reset();
    t_line_wrap();
    t_patterns();
    t_frame_mid();
    t_frame_on_load();
    t_frame_hold();
    repeat (37) step(1'b0);
    t_reset();                  // R1 mid-line reset
    repeat (30) step(1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule